// File: doc/BRIEF.md
# Paged Processor Register Port

This block is the control port of a peripheral. A host processor reaches it through an 8-bit data bus, a 5-bit address and three active-low strobes (chip enable, read, write). The low end of the address space holds eight global registers. One of them is a page selector that picks one of 128 pages of sixteen registers. The upper half of the address space opens a window onto the selected page. The configured registers go to the core logic as flat outputs. The core also gets a one-cycle notice after each completed write to a global register, so that sync-type registers act only on settled values.

All strobe, address and data inputs are sampled on `clk`, so the host bus is assumed to be synchronised or slow relative to the clock. Writes use one of two timings, picked by bit 0 of global register 0. With the bit clear, a write is transparent: the addressed register follows the bus on every clock while both chip enable and write are low. With the bit set, a write takes effect only when the combined strobe (chip enable OR write, both active-low) rises. The value taken is the address and data last sampled while the strobe was still low. The read path produces a data word and an active-high enable for an external tristate pad. This supports both the usual separate read strobe and the wiring where read is tied low and write gives the direction.

Top module: `mpi_paged_regif`

## Requirements
- R1: During and after reset all global registers and all paged registers read zero, `glob_chg` is zero and `dout_oe` is low while no strobe is active.
- R2: With bit 0 of global register 0 clear, a register written at address A takes the value on `din` in the clock after a cycle in which `ce_n` and `wr_n` are both low, and follows each later `din` change while both stay low.
- R3: Once `ce_n` or `wr_n` returns high, the written register holds its value regardless of later `din` changes.
- R4: With bit 0 of global register 0 set, no register changes while `ce_n` and `wr_n` are both low. When either strobe rises, the register at the last sampled address takes the last sampled data, visible one clock later.
- R5: Global address 2 is the page register. Its low 7 bits select the page, and bit 7 has no effect on selection. Addresses 16 to 31 reach register (address − 16) of the selected page, for both reads and writes.
- R6: Writes to addresses 8 to 15 change no register, and reads from them return zero.
- R7: `dout_oe` is high exactly when `ce_n` and `rd_n` are low and `wr_n` is high.
- R8: While `dout_oe` is high, `dout` carries the addressed register. Addresses 0 to 7 read the global registers directly. `glob_regs[8*i+7:8*i]` always shows global register i.
- R9: With `rd_n` held low, a transfer with `wr_n` low writes and a transfer with `wr_n` high reads, with `ce_n` as the strobe.
- R10: After each completed write (combined strobe rise) to a global address i, `glob_chg[i]` is high for exactly one clock and all other bits are low. `glob_chg` is zero while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 5 | Register address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the pad (zero when not enabled) |
| dout_oe | output | 1 | Pad output enable, active high |
| glob_regs | output | 64 | Global registers, register i in bits 8i+7..8i |
| glob_chg | output | 8 | One-cycle pulse per global register after a completed write |

## Verification
The hardest condition to reach from the ports is a rising-edge write in which the bus changed during the low phase. The register must then take the final value and never show the transient one. The stimulus first writes the mode bit, then holds chip enable and write low while changing `din` over several clocks, checking the register stays put, and releases only `wr_n` while `ce_n` is still low. Every page is filled and read back with an arithmetic pattern. Bit 7 of the page register is toggled during readback to show it is ignored.

// File: rtl/mpi_pkg.sv
package mpi_pkg;

    localparam int MPI_AW        = 5;
    localparam int MPI_DW        = 8;
    localparam int MPI_N_GLOB    = 8;
    localparam int MPI_PAGES     = 128;
    localparam int MPI_PAGE_REGS = 16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_GLOB = 2'd1,
        TGT_PAGE = 2'd2
    } tgt_e;

endpackage

// File: rtl/mpi_strobe_track.sv
module mpi_strobe_track #(
    parameter int AW = mpi_pkg::MPI_AW,
    parameter int DW = mpi_pkg::MPI_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_act,
    output logic          wr_rise,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_data
);

    typedef struct packed {
        logic          act;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } trk_t;

    trk_t st_d, st_q;

    // combined strobe is low only when both active-low strobes are low
    assign wr_act = ~(ce_n | wr_n);

    always_comb begin
        st_d     = st_q;
        st_d.act = wr_act;
        if (wr_act) begin
            st_d.addr = addr;
            st_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_rise   = st_q.act & ~wr_act;
    assign hold_addr = st_q.addr;
    assign hold_data = st_q.data;

endmodule

// File: rtl/mpi_global_bank.sv
module mpi_global_bank #(
    parameter int DW     = mpi_pkg::MPI_DW,
    parameter int N_GLOB = mpi_pkg::MPI_N_GLOB,
    localparam int GI_W  = $clog2(N_GLOB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [GI_W-1:0]      widx,
    input  logic [DW-1:0]        wdata,
    input  logic                 chg_en,
    input  logic [GI_W-1:0]      chg_idx,
    output logic [N_GLOB*DW-1:0] regs,
    output logic [N_GLOB-1:0]    chg
);

    typedef struct packed {
        logic [N_GLOB-1:0][DW-1:0] regs;
        logic [N_GLOB-1:0]         chg;
    } gb_t;

    gb_t gb_d, gb_q;

    always_comb begin
        gb_d     = gb_q;
        gb_d.chg = '0;
        if (we) begin
            gb_d.regs[widx] = wdata;
        end
        if (chg_en) begin
            gb_d.chg[chg_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gb_q <= '0;
        end else begin
            gb_q <= gb_d;
        end
    end

    generate
        for (genvar g = 0; g < N_GLOB; g++) begin : g_flat
            assign regs[g*DW +: DW] = gb_q.regs[g];
        end
    endgenerate

    assign chg = gb_q.chg;

endmodule

// File: rtl/mpi_page_bank.sv
module mpi_page_bank #(
    parameter int DW        = mpi_pkg::MPI_DW,
    parameter int PAGES     = mpi_pkg::MPI_PAGES,
    parameter int PAGE_REGS = mpi_pkg::MPI_PAGE_REGS,
    localparam int PAGE_W   = $clog2(PAGES),
    localparam int IDX_W    = $clog2(PAGE_REGS),
    localparam int DEPTH    = PAGES * PAGE_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DW-1:0]     wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DW-1:0]     rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (we) begin
            pb_d.mem[{page, widx}] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign rdata = pb_q.mem[{page, ridx}];

endmodule

// File: rtl/mpi_paged_regif.sv
module mpi_paged_regif #(
    parameter int AW        = mpi_pkg::MPI_AW,
    parameter int DW        = mpi_pkg::MPI_DW,
    parameter int N_GLOB    = mpi_pkg::MPI_N_GLOB,
    parameter int PAGES     = mpi_pkg::MPI_PAGES,
    parameter int PAGE_REGS = mpi_pkg::MPI_PAGE_REGS,
    parameter int PAGE_REG  = 2,
    parameter int EDGE_REG  = 0,
    parameter int EDGE_BIT  = 0,
    localparam int PAGE_W   = $clog2(PAGES),
    localparam int IDX_W    = $clog2(PAGE_REGS),
    localparam int GI_W     = $clog2(N_GLOB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        din,
    output logic [DW-1:0]        dout,
    output logic                 dout_oe,
    output logic [N_GLOB*DW-1:0] glob_regs,
    output logic [N_GLOB-1:0]    glob_chg
);

    import mpi_pkg::*;

    localparam logic [AW-1:0] GLOB_LIM = AW'(N_GLOB);
    localparam logic [AW-1:0] WIN_BASE = AW'((1 << AW) - PAGE_REGS);

    function automatic tgt_e classify(input logic [AW-1:0] a);
        if (a < GLOB_LIM) begin
            return TGT_GLOB;
        end else if (a >= WIN_BASE) begin
            return TGT_PAGE;
        end
        return TGT_NONE;
    endfunction

    logic          wr_act, wr_rise;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    mpi_strobe_track #(.AW(AW), .DW(DW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (din),
        .wr_act    (wr_act),
        .wr_rise   (wr_rise),
        .hold_addr (hold_addr),
        .hold_data (hold_data)
    );

    logic              edge_mode;
    logic [PAGE_W-1:0] page_sel;
    logic              w_en;
    logic [AW-1:0]     w_addr;
    logic [DW-1:0]     w_data;
    tgt_e              w_tgt, hold_tgt, r_tgt;
    logic              glob_we, page_we, chg_en;
    logic [DW-1:0]     page_rdata;
    logic [DW-1:0]     rd_word;

    assign edge_mode = glob_regs[EDGE_REG*DW + EDGE_BIT];
    assign page_sel  = glob_regs[PAGE_REG*DW +: PAGE_W];

    always_comb begin
        w_en     = edge_mode ? wr_rise   : wr_act;
        w_addr   = edge_mode ? hold_addr : addr;
        w_data   = edge_mode ? hold_data : din;
        w_tgt    = classify(w_addr);
        hold_tgt = classify(hold_addr);
        glob_we  = w_en && (w_tgt == TGT_GLOB);
        page_we  = w_en && (w_tgt == TGT_PAGE);
        chg_en   = wr_rise && (hold_tgt == TGT_GLOB);
    end

    mpi_global_bank #(.DW(DW), .N_GLOB(N_GLOB)) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (glob_we),
        .widx    (w_addr[GI_W-1:0]),
        .wdata   (w_data),
        .chg_en  (chg_en),
        .chg_idx (hold_addr[GI_W-1:0]),
        .regs    (glob_regs),
        .chg     (glob_chg)
    );

    mpi_page_bank #(.DW(DW), .PAGES(PAGES), .PAGE_REGS(PAGE_REGS)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .page  (page_sel),
        .widx  (w_addr[IDX_W-1:0]),
        .wdata (w_data),
        .ridx  (addr[IDX_W-1:0]),
        .rdata (page_rdata)
    );

    always_comb begin
        r_tgt = classify(addr);
        case (r_tgt)
            TGT_GLOB: rd_word = glob_regs[addr[GI_W-1:0]*DW +: DW];
            TGT_PAGE: rd_word = page_rdata;
            default:  rd_word = '0;
        endcase
        dout_oe = ~ce_n & ~rd_n & wr_n;
        dout    = dout_oe ? rd_word : '0;
    end

endmodule

// File: rtl/mpi_paged_regif_chk.sv
module mpi_paged_regif_chk #(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int N_GLOB   = 8,
    parameter int EDGE_REG = 0,
    parameter int EDGE_BIT = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_n,
    input logic                 wr_n,
    input logic [AW-1:0]        addr,
    input logic [DW-1:0]        dout,
    input logic                 dout_oe,
    input logic [N_GLOB*DW-1:0] glob_regs,
    input logic [N_GLOB-1:0]    glob_chg
);

    localparam logic [AW-1:0] GAP_LO = AW'(N_GLOB);
    localparam logic [AW-1:0] GAP_HI = AW'(15);

    logic edge_on;
    logic in_gap;
    assign edge_on = glob_regs[EDGE_REG*DW + EDGE_BIT];
    assign in_gap  = (addr >= GAP_LO) && (addr <= GAP_HI);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_clear_chk: assert (glob_regs == '0 && glob_chg == '0);
        end
    end

    // R10
    chg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(glob_chg));

    // R10
    chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_chg != '0) |=> (glob_chg == '0));

    // R10
    chg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !wr_n && $past(!ce_n && !wr_n)) |-> (glob_chg == '0));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_on && !ce_n && !wr_n) |=> $stable(glob_regs));

    // R6
    gap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_on && !ce_n && !wr_n && in_gap) |=> $stable(glob_regs));

    // R6
    gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && in_gap) |-> (dout == '0));

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!ce_n && wr_n));

endmodule

bind mpi_paged_regif mpi_paged_regif_chk #(
    .AW(AW), .DW(DW), .N_GLOB(N_GLOB), .EDGE_REG(EDGE_REG), .EDGE_BIT(EDGE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .glob_regs (glob_regs),
    .glob_chg  (glob_chg)
);

// File: tb/tb_mpi_paged_regif.sv
module tb_mpi_paged_regif;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic [63:0] glob_regs;
    logic [7:0]  glob_chg;
    wire  [7:0]  bus;

    int total = 0;
    int bad = 0;
    bit rd_tied = 1'b0;

    logic [7:0] mg [8];
    logic [7:0] mp [128][16];

    always #(CLK_P/2) clk = ~clk;

    assign bus = dout_oe ? dout : 8'hzz;

    mpi_paged_regif dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .glob_regs(glob_regs), .glob_chg(glob_chg)
    );

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((p * 7 + i * 13 + 1) & 255);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 5'(a); din = 8'(d); ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        addr = 5'(a); ce_n = 1'b0; rd_n = 1'b0;
        #(CLK_P/4);
        v = bus;
        ce_n = 1'b1; rd_n = rd_tied ? 1'b0 : 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 8; i++) mg[i] = 8'h00;
        for (int p = 0; p < 128; p++) for (int i = 0; i < 16; i++) mp[p][i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 regs", 8'(glob_regs != 0), 8'h00);
        check("R1 chg", glob_chg, 8'h00);
        check("R1 oe", 8'(dout_oe), 8'h00);
        rst_n = 1'b1;
        rd(16, v); check("R1 page0", v, 8'h00);
        rd(31, v); check("R1 page0 top", v, 8'h00);
        rd(5, v);  check("R1 glob", v, 8'h00);

        // R8 globals
        for (int i = 1; i < 8; i++) begin
            if (i == 2) continue;
            wr(i, i * 37 + 3); mg[i] = 8'(i * 37 + 3);
        end
        wr(0, 8'hF0); mg[0] = 8'hF0;
        for (int i = 0; i < 8; i++) begin
            if (i == 2) continue;
            rd(i, v); check("R8 glob read", v, mg[i]);
            check("R8 glob out", glob_regs[i*8 +: 8], mg[i]);
        end

        // R5 fill all pages then read back
        for (int p = 0; p < 128; p++) begin
            wr(2, p);
            for (int i = 0; i < 16; i++) begin
                wr(16 + i, pat(p, i)); mp[p][i] = pat(p, i);
            end
        end
        for (int p = 0; p < 128; p++) begin
            wr(2, p | ((p & 1) << 7));
            for (int i = 0; i < 16; i++) begin
                rd(16 + i, v); check("R5 page read", v, mp[p][i]);
            end
        end

        // R2 / R3 / R10 level write
        @(negedge clk);
        addr = 5'd3; din = 8'h11; ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        check("R2 follow1", glob_regs[24 +: 8], 8'h11);
        check("R10 quiet low", glob_chg, 8'h00);
        din = 8'h22;
        @(negedge clk);
        check("R2 follow2", glob_regs[24 +: 8], 8'h22);
        ce_n = 1'b1;
        @(negedge clk);
        check("R10 pulse", glob_chg, 8'h08);
        check("R3 held", glob_regs[24 +: 8], 8'h22);
        din = 8'h44;
        @(negedge clk);
        check("R10 one cycle", glob_chg, 8'h00);
        check("R3 held wr low", glob_regs[24 +: 8], 8'h22);
        wr_n = 1'b1; mg[3] = 8'h22;
        @(negedge clk);
        check("R3 held end", glob_regs[24 +: 8], 8'h22);

        // R4 edge mode
        wr(0, 8'hF1); mg[0] = 8'hF1;
        check("R4 mode set", glob_regs[7:0], 8'hF1);
        @(negedge clk);
        addr = 5'd4; din = 8'h55; ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        check("R4 no change low", glob_regs[32 +: 8], mg[4]);
        din = 8'hAA;
        @(negedge clk);
        check("R4 no transient", glob_regs[32 +: 8], mg[4]);
        wr_n = 1'b1;
        @(negedge clk);
        check("R4 capture", glob_regs[32 +: 8], 8'hAA);
        check("R10 edge pulse", glob_chg, 8'h10);
        ce_n = 1'b1; mg[4] = 8'hAA;
        wr(2, 9);
        wr(20, 8'h3C); mp[9][4] = 8'h3C;
        rd(20, v); check("R4 page edge", v, 8'h3C);
        wr(0, 8'hF0); mg[0] = 8'hF0;
        check("R4 mode clear", glob_regs[7:0], 8'hF0);

        // R6 unmapped
        wr(9, 8'h77);
        wr(12, 8'h5A);
        rd(9, v);  check("R6 read 9", v, 8'h00);
        rd(12, v); check("R6 read 12", v, 8'h00);
        rd(15, v); check("R6 read 15", v, 8'h00);
        for (int i = 0; i < 8; i++) begin
            if (i == 2) continue;
            check("R6 glob intact", glob_regs[i*8 +: 8], mg[i]);
        end
        for (int i = 0; i < 16; i++) begin
            rd(16 + i, v); check("R6 page intact", v, mp[9][i]);
        end

        // R7 strobe combinations
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            addr = 5'd8;
            ce_n = c[0]; rd_n = c[1]; wr_n = c[2];
            #(CLK_P/4);
            check("R7 oe", 8'(dout_oe), 8'(!c[0] && !c[1] && c[2]));
            @(negedge clk);
            ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        end

        // R9 read strobe tied low
        rd_tied = 1'b1; rd_n = 1'b0;
        wr(5, 8'h6B); mg[5] = 8'h6B;
        rd(5, v); check("R9 glob", v, 8'h6B);
        wr(2, 33);
        wr(27, 8'hC5); mp[33][11] = 8'hC5;
        rd(27, v); check("R9 page", v, 8'hC5);
        rd(16, v); check("R9 page other", v, mp[33][0]);
        rd_tied = 1'b0; rd_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule